// File: doc/BRIEF.md
# Stop-Mode Power Save Controller

This block puts a small microcontroller subsystem into a low-power STOP state and brings it back out. Software writes a one-cycle strobe to a STOP command register. From the next cycle the controller removes the main clock enable and tells the peripherals to halt. All registers and the controller's own state are kept as they are. The controller runs on an always-running low-speed clock, so it can still watch for wake events while the main clock is off.

Wake events are passed through a two-flip-flop synchronizer and then qualified. The qualifying events are a non-maskable request from the NMI pin or from the watchdog, an unmasked external interrupt, or an unmasked interrupt from a peripheral that keeps running in STOP. A three-bit control register holds one disable bit for each NMI source and one disable bit for the whole maskable class. When digital noise filtering is enabled on one chosen external interrupt pin, that pin is removed from the wake sources. An asynchronous reset ends STOP in every case and returns all state to normal mode. After an interrupt wake the request is not consumed; the interrupt controller services it.

The block also handles the analog-to-digital converter (ADC). If the ADC is converting when STOP is entered, the block pauses it and sends a resume pulse at wake. A result-invalid flag is held high from STOP entry until two conversions have completed after wake.

Top module: `stop_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in normal mode: `in_stop`=0, `main_clk_en`=1, `periph_halt`=0, `adc_pause`=0, `adc_resume`=0 and `adc_result_invalid`=0. The control register is cleared to 0, which enables every wake class. A reset applied during STOP also ends STOP.
- R2: A one-cycle `stop_cmd_wr` in normal mode puts the block into STOP from the next cycle: `in_stop`=1, `main_clk_en`=0 and `periph_halt`=1.
- R3: In STOP, a wake input that qualifies ends STOP. It is sampled on three rising edges: two synchronizer stages and the state register. After the second edge `in_stop` is still 1. After the third edge `in_stop`=0 and `main_clk_en`=1. `nmi_pin_req` and `wdt_nmi_req` each qualify unless their disable bit is set.
- R4: Control register bits, written with `ctl_wr`/`ctl_wdata`:
  - bit 0 disables `nmi_pin_req`.
  - bit 1 disables `wdt_nmi_req`.
  - bit 2 disables all of `ext_irq` and `int_irq`.

  A request whose class is disabled leaves the block in STOP.
- R5: `ext_irq[i]` wakes the block when `ext_irq_mask[i]`=0. When the mask bit is 1 it does not wake the block.
- R6: `int_irq[j]` wakes the block when `int_irq_mask[j]`=0. When the mask bit is 1 it does not wake the block.
- R7: With `filt_en`=1, `ext_irq[FILT_PIN]` (pin 3 by default) cannot wake the block; the other external pins are not affected. With `filt_en`=0 that pin wakes the block like the others.
- R8: If `adc_busy`=1 in the cycle the STOP strobe is taken, `adc_pause` is 1 from the next cycle until wake. `adc_resume` is then 1 for exactly the first normal-mode cycle. If the ADC was idle at entry, neither output is asserted.
- R9: `adc_result_invalid` is 1 from STOP entry through STOP. After wake it stays 1 until two `adc_done` pulses have been taken in normal mode, and it falls after the second one. Later pulses keep it 0. `adc_done` pulses during STOP are not counted.
- R10: The control register keeps its value across STOP and wake. A disable that was set before STOP still applies on the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk | input | 1 | Always-running low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_cmd_wr | input | 1 | One-cycle STOP command strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit0 pin NMI off, bit1 watchdog NMI off, bit2 maskable off |
| nmi_pin_req | input | 1 | NMI pin request |
| wdt_nmi_req | input | 1 | Watchdog non-maskable request |
| ext_irq | input | N_EXT | External interrupt requests |
| ext_irq_mask | input | N_EXT | External interrupt masks, 1 = masked |
| int_irq | input | N_INT | Requests from peripherals that run in STOP |
| int_irq_mask | input | N_INT | Internal interrupt masks, 1 = masked |
| filt_en | input | 1 | Noise filter enabled on pin FILT_PIN |
| adc_busy | input | 1 | ADC conversion in progress |
| adc_done | input | 1 | ADC conversion-complete pulse |
| main_clk_en | output | 1 | Main clock enable, 0 in STOP |
| periph_halt | output | 1 | Halt command to peripherals |
| in_stop | output | 1 | Block is in STOP |
| adc_pause | output | 1 | ADC paused by STOP |
| adc_resume | output | 1 | One-cycle ADC restart pulse at wake |
| adc_result_invalid | output | 1 | Current ADC results are not valid |

## Verification
The hardest cases to reach are the combinations: each wake source crossed with every control register value, both filter settings and both mask settings. A failure in any one of these cases leaves the block stuck in STOP, with the main clock off. The bench handles this with a sweep. For each case it resets, programs the control register and masks, enters STOP and raises a single source. It checks `in_stop` one edge before and at the exact release edge, then resets so the next case starts clean. The ADC invalid window is reached the same way. The bench wakes the block, then counts `adc_done` pulses one at a time, and also sends pulses during STOP to show that they are not counted.

// File: rtl/stopc_pkg.sv
package stopc_pkg;

  localparam int CTL_W = 3;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STOP = 1'b1
  } pm_state_e;

  typedef struct packed {
    logic dis_maskable;
    logic dis_nmi_wdt;
    logic dis_nmi_pin;
  } pm_ctl_t;

endpackage

// File: rtl/stopc_sync.sv
module stopc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;
  logic [W-1:0] s1_d;
  logic [W-1:0] s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/stopc_wake_qual.sv
module stopc_wake_qual
  import stopc_pkg::*;
#(
  parameter int N_EXT    = 4,
  parameter int N_INT    = 3,
  parameter int FILT_PIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pm_ctl_t          ctl,
  input  logic             filt_en,
  input  logic             nmi_pin_s,
  input  logic             wdt_nmi_s,
  input  logic [N_EXT-1:0] ext_s,
  input  logic [N_EXT-1:0] ext_mask,
  input  logic [N_INT-1:0] int_s,
  input  logic [N_INT-1:0] int_mask,
  output logic             wake
);

  logic [N_EXT-1:0] filt_vec;
  logic [N_EXT-1:0] ext_eff;
  logic [N_INT-1:0] int_eff;
  logic             nmi_ok;
  logic             mask_ok;

  genvar gi;
  generate
    for (gi = 0; gi < N_EXT; gi++) begin : g_ext
      assign filt_vec[gi] = filt_en && (gi == FILT_PIN);
      assign ext_eff[gi]  = ext_s[gi] && !ext_mask[gi] && !filt_vec[gi];
    end
    for (gi = 0; gi < N_INT; gi++) begin : g_int
      assign int_eff[gi] = int_s[gi] && !int_mask[gi];
    end
  endgenerate

  always_comb begin
    nmi_ok  = (nmi_pin_s && !ctl.dis_nmi_pin) || (wdt_nmi_s && !ctl.dis_nmi_wdt);
    mask_ok = !ctl.dis_maskable && ((|ext_eff) || (|int_eff));
    wake    = nmi_ok || mask_ok;
  end

  // R4: with maskable class disabled and no NMI input active, nothing qualifies
  a_r4_masked_class_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.dis_maskable && !nmi_pin_s && !wdt_nmi_s) |-> !wake);

  // R7: filtered pin alone never qualifies
  a_r7_filtered_pin_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !nmi_pin_s && !wdt_nmi_s && (int_s == '0) &&
     ((ext_s & ~(N_EXT'(1) << FILT_PIN)) == '0)) |-> !wake);

endmodule

// File: rtl/stopc_adc_guard.sv
module stopc_adc_guard #(
  parameter int INV_CONV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_stop,
  input  logic leave_stop,
  input  logic in_stop,
  input  logic adc_busy,
  input  logic adc_done,
  output logic adc_pause,
  output logic adc_resume,
  output logic adc_result_invalid
);

  localparam int CNT_W = (INV_CONV < 1) ? 1 : $clog2(INV_CONV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             pause_q;
  logic             pause_d;
  logic             resume_q;
  logic             resume_d;
  logic             cnt_en;

  always_comb begin
    pause_d  = pause_q;
    resume_d = 1'b0;
    if (enter_stop) begin
      pause_d = adc_busy;
    end else if (leave_stop) begin
      pause_d  = 1'b0;
      resume_d = pause_q;
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (leave_stop) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(INV_CONV);
    end else if (!in_stop && adc_done && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      pause_q  <= pause_d;
      resume_q <= resume_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign adc_pause          = pause_q;
  assign adc_resume         = resume_q;
  assign adc_result_invalid = in_stop || (cnt_q != '0);

  // R9: count window bounded
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(INV_CONV));

  // R9: flag held whenever STOP is active
  a_r9_invalid_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> adc_result_invalid);

  // R8: restart pulse only right after STOP ended
  a_r8_resume_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    adc_resume |-> ($past(in_stop) && !in_stop));

  // R8: pause never seen in normal mode
  a_r8_pause_only_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    adc_pause |-> in_stop);

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import stopc_pkg::*;
#(
  parameter int N_EXT    = 4,
  parameter int N_INT    = 3,
  parameter int FILT_PIN = 3,
  parameter int INV_CONV = 2
) (
  input  logic             aon_clk,
  input  logic             rst_n,
  input  logic             stop_cmd_wr,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             nmi_pin_req,
  input  logic             wdt_nmi_req,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_irq_mask,
  input  logic [N_INT-1:0] int_irq,
  input  logic [N_INT-1:0] int_irq_mask,
  input  logic             filt_en,
  input  logic             adc_busy,
  input  logic             adc_done,
  output logic             main_clk_en,
  output logic             periph_halt,
  output logic             in_stop,
  output logic             adc_pause,
  output logic             adc_resume,
  output logic             adc_result_invalid
);

  localparam int SYNC_W = N_EXT + N_INT + 2;

  pm_state_e         state_q;
  pm_state_e         state_d;
  pm_ctl_t           ctl_q;
  pm_ctl_t           ctl_d;
  logic [SYNC_W-1:0] raw_req;
  logic [SYNC_W-1:0] sync_req;
  logic              wake;
  logic              enter_stop;
  logic              leave_stop;

  assign raw_req = {int_irq, ext_irq, wdt_nmi_req, nmi_pin_req};

  stopc_sync #(.W(SYNC_W)) u_sync (
    .clk   (aon_clk),
    .rst_n (rst_n),
    .d     (raw_req),
    .q     (sync_req)
  );

  stopc_wake_qual #(
    .N_EXT    (N_EXT),
    .N_INT    (N_INT),
    .FILT_PIN (FILT_PIN)
  ) u_qual (
    .clk       (aon_clk),
    .rst_n     (rst_n),
    .ctl       (ctl_q),
    .filt_en   (filt_en),
    .nmi_pin_s (sync_req[0]),
    .wdt_nmi_s (sync_req[1]),
    .ext_s     (sync_req[2 +: N_EXT]),
    .ext_mask  (ext_irq_mask),
    .int_s     (sync_req[2+N_EXT +: N_INT]),
    .int_mask  (int_irq_mask),
    .wake      (wake)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d = pm_ctl_t'(ctl_wdata);
    end
  end

  always_comb begin
    enter_stop = 1'b0;
    leave_stop = 1'b0;
    state_d    = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_cmd_wr) begin
          enter_stop = 1'b1;
          state_d    = ST_STOP;
        end
      end
      ST_STOP: begin
        if (wake) begin
          leave_stop = 1'b1;
          state_d    = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge aon_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge aon_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign in_stop     = (state_q == ST_STOP);
  assign main_clk_en = !in_stop;
  assign periph_halt = in_stop;

  stopc_adc_guard #(.INV_CONV(INV_CONV)) u_adc (
    .clk                (aon_clk),
    .rst_n              (rst_n),
    .enter_stop         (enter_stop),
    .leave_stop         (leave_stop),
    .in_stop            (in_stop),
    .adc_busy           (adc_busy),
    .adc_done           (adc_done),
    .adc_pause          (adc_pause),
    .adc_resume         (adc_resume),
    .adc_result_invalid (adc_result_invalid)
  );

  // R2: clock gate drops the cycle after the strobe in normal mode
  a_r2_gate_after_cmd: assert property (@(posedge aon_clk) disable iff (!rst_n)
    (!in_stop && stop_cmd_wr) |=> (!main_clk_en && periph_halt));

  // R3: STOP only ends when the qualifier reported a wake
  a_r3_release_needs_wake: assert property (@(posedge aon_clk) disable iff (!rst_n)
    (in_stop && !wake) |=> in_stop);

  // R10: control register only changes on a write strobe
  a_r10_ctl_retained: assert property (@(posedge aon_clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q));

endmodule

// File: tb/test_stop_mode_ctrl.sv
module test_stop_mode_ctrl;

  localparam int N_EXT    = 4;
  localparam int N_INT    = 3;
  localparam int FILT_PIN = 3;

  logic             aon_clk = 1'b0;
  logic             rst_n;
  logic             stop_cmd_wr;
  logic             ctl_wr;
  logic [2:0]       ctl_wdata;
  logic             nmi_pin_req;
  logic             wdt_nmi_req;
  logic [N_EXT-1:0] ext_irq;
  logic [N_EXT-1:0] ext_irq_mask;
  logic [N_INT-1:0] int_irq;
  logic [N_INT-1:0] int_irq_mask;
  logic             filt_en;
  logic             adc_busy;
  logic             adc_done;
  logic             main_clk_en;
  logic             periph_halt;
  logic             in_stop;
  logic             adc_pause;
  logic             adc_resume;
  logic             adc_result_invalid;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 aon_clk = ~aon_clk;

  stop_mode_ctrl #(
    .N_EXT(N_EXT), .N_INT(N_INT), .FILT_PIN(FILT_PIN), .INV_CONV(2)
  ) i_stop_mode_ctrl (
    .aon_clk(aon_clk), .rst_n(rst_n), .stop_cmd_wr(stop_cmd_wr),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .nmi_pin_req(nmi_pin_req),
    .wdt_nmi_req(wdt_nmi_req), .ext_irq(ext_irq), .ext_irq_mask(ext_irq_mask),
    .int_irq(int_irq), .int_irq_mask(int_irq_mask), .filt_en(filt_en),
    .adc_busy(adc_busy), .adc_done(adc_done), .main_clk_en(main_clk_en),
    .periph_halt(periph_halt), .in_stop(in_stop), .adc_pause(adc_pause),
    .adc_resume(adc_resume), .adc_result_invalid(adc_result_invalid)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge aon_clk);
    @(negedge aon_clk);
  endtask

  task automatic clear_inputs;
    stop_cmd_wr = 0; ctl_wr = 0; ctl_wdata = 0;
    nmi_pin_req = 0; wdt_nmi_req = 0; ext_irq = 0; ext_irq_mask = 0;
    int_irq = 0; int_irq_mask = 0; filt_en = 0; adc_busy = 0; adc_done = 0;
  endtask

  task automatic do_reset;
    @(negedge aon_clk);
    rst_n = 1'b0;
    clear_inputs();
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic write_ctl(input logic [2:0] v);
    ctl_wr = 1; ctl_wdata = v;
    step(1);
    ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic enter_stop(input logic busy, input bit verbose);
    stop_cmd_wr = 1; adc_busy = busy;
    step(1);
    stop_cmd_wr = 0; adc_busy = 0;
    if (verbose) begin
      chk(in_stop, 1'b1, "R2", "in_stop after strobe");
      chk(main_clk_en, 1'b0, "R2", "main_clk_en after strobe");
      chk(periph_halt, 1'b1, "R2", "periph_halt after strobe");
    end else begin
      chk(in_stop, 1'b1, "R2", "in_stop after strobe");
    end
  endtask

  task automatic adc_pulse;
    adc_done = 1;
    step(1);
    adc_done = 0;
  endtask

  // kind: 0 pin NMI, 1 watchdog NMI, 2 external, 3 internal
  task automatic wake_case(input int kind, input int idx, input logic m,
                           input logic [2:0] ctl, input logic filt);
    logic  exp_wake;
    string tag;
    do_reset();
    write_ctl(ctl);
    filt_en = filt;
    ext_irq_mask = {N_EXT{m}};
    int_irq_mask = {N_INT{m}};
    enter_stop(1'b0, 1'b0);
    case (kind)
      0: begin nmi_pin_req = 1; exp_wake = !ctl[0]; tag = ctl[0] ? "R4" : "R3"; end
      1: begin wdt_nmi_req = 1; exp_wake = !ctl[1]; tag = ctl[1] ? "R4" : "R3"; end
      2: begin
        ext_irq[idx] = 1'b1;
        exp_wake = !ctl[2] && !m && !(filt && idx == FILT_PIN);
        if (filt && idx == FILT_PIN) tag = "R7";
        else if (ctl[2]) tag = "R4";
        else tag = "R5";
      end
      default: begin
        int_irq[idx] = 1'b1;
        exp_wake = !ctl[2] && !m;
        tag = ctl[2] ? "R4" : "R6";
      end
    endcase
    step(2);
    chk(in_stop, 1'b1, tag, $sformatf("still stopped after 2 edges k%0d i%0d", kind, idx));
    step(1);
    chk(in_stop, !exp_wake, tag,
        $sformatf("in_stop k%0d i%0d m%0b ctl%0d f%0b", kind, idx, m, ctl, filt));
    chk(main_clk_en, exp_wake, tag, "main_clk_en at release edge");
  endtask

  initial begin
    rst_n = 1'b0;
    clear_inputs();
    step(1);
    chk(in_stop, 1'b0, "R1", "in_stop during reset");
    chk(main_clk_en, 1'b1, "R1", "main_clk_en during reset");
    rst_n = 1'b1;
    step(1);
    chk(periph_halt, 1'b0, "R1", "periph_halt after reset");
    chk(adc_pause, 1'b0, "R1", "adc_pause after reset");
    chk(adc_resume, 1'b0, "R1", "adc_resume after reset");
    chk(adc_result_invalid, 1'b0, "R1", "invalid after reset");

    // Sweep wake sources against control register, filter and masks
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 2; f++) begin
        wake_case(0, 0, 1'b0, 3'(c), 1'(f));
        wake_case(1, 0, 1'b0, 3'(c), 1'(f));
        for (int m = 0; m < 2; m++) begin
          for (int i = 0; i < N_EXT; i++) wake_case(2, i, 1'(m), 3'(c), 1'(f));
          for (int j = 0; j < N_INT; j++) wake_case(3, j, 1'(m), 3'(c), 1'(f));
        end
      end
    end

    // R1: reset during STOP, control register cleared
    do_reset();
    write_ctl(3'b111);
    enter_stop(1'b1, 1'b1);
    @(negedge aon_clk);
    rst_n = 1'b0;
    step(1);
    chk(in_stop, 1'b0, "R1", "reset ends STOP");
    chk(adc_pause, 1'b0, "R1", "reset clears pause");
    rst_n = 1'b1;
    step(1);
    enter_stop(1'b0, 1'b0);
    nmi_pin_req = 1;
    step(3);
    chk(in_stop, 1'b0, "R1", "ctl cleared so pin NMI wakes");
    nmi_pin_req = 0;

    // R10: disable bit retained across STOP
    do_reset();
    write_ctl(3'b001);
    enter_stop(1'b0, 1'b0);
    wdt_nmi_req = 1;
    step(3);
    chk(in_stop, 1'b0, "R10", "wdt wake");
    wdt_nmi_req = 0;
    step(3);
    enter_stop(1'b0, 1'b0);
    nmi_pin_req = 1;
    step(4);
    chk(in_stop, 1'b1, "R10", "pin NMI still disabled after wake");
    nmi_pin_req = 0;

    // R8, R9: ADC busy at entry
    do_reset();
    enter_stop(1'b1, 1'b1);
    chk(adc_pause, 1'b1, "R8", "pause in STOP");
    chk(adc_result_invalid, 1'b1, "R9", "invalid in STOP");
    adc_pulse();
    adc_pulse();
    chk(adc_result_invalid, 1'b1, "R9", "done in STOP not counted");
    nmi_pin_req = 1;
    step(3);
    nmi_pin_req = 0;
    chk(in_stop, 1'b0, "R8", "woken");
    chk(adc_pause, 1'b0, "R8", "pause dropped at wake");
    chk(adc_resume, 1'b1, "R8", "resume pulse");
    chk(adc_result_invalid, 1'b1, "R9", "invalid right after wake");
    step(1);
    chk(adc_resume, 1'b0, "R8", "resume one cycle");
    chk(adc_result_invalid, 1'b1, "R9", "invalid before conversions");
    adc_pulse();
    chk(adc_result_invalid, 1'b1, "R9", "invalid after first conversion");
    adc_pulse();
    chk(adc_result_invalid, 1'b0, "R9", "valid after second conversion");
    adc_pulse();
    chk(adc_result_invalid, 1'b0, "R9", "valid after third conversion");

    // R8: ADC idle at entry
    enter_stop(1'b0, 1'b0);
    chk(adc_pause, 1'b0, "R8", "no pause when idle");
    chk(adc_result_invalid, 1'b1, "R9", "invalid in second STOP");
    int_irq[0] = 1;
    step(3);
    int_irq[0] = 0;
    chk(in_stop, 1'b0, "R6", "internal wake");
    chk(adc_resume, 1'b0, "R8", "no resume when idle");
    step(1);
    chk(adc_resume, 1'b0, "R8", "no resume later");
    chk(adc_result_invalid, 1'b1, "R9", "invalid window reloaded");
    adc_pulse();
    adc_pulse();
    chk(adc_result_invalid, 1'b0, "R9", "valid after two conversions");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge aon_clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule